// File: doc/BRIEF.md
# Token Forwarding Communication Assist

This block is a small transfer engine placed next to a processor inside a tile. The processor writes each output token into a circular buffer in its own local memory and then pulses a "token produced" strobe. From then on the engine does the work. It fetches the token's words through the tile memory arbiter and writes them into a circular buffer in a remote tile as posted writes. After the data words it sends one extra word that tells the consumer the token is complete. The processor never writes to a remote tile. When the interconnect is slow, only the engine waits, so the processor's run time does not depend on network load.

Each remote buffer slot holds one token plus its completion word. The engine sends a token only when the remote buffer has a free slot, which it tracks with a credit counter that the consumer side refills one token at a time. Tokens are started no closer together than a programmed number of idle cycles. Traffic on the interconnect is therefore spread out at an even rate instead of arriving in bursts. While `run` is low, the engine is held idle and loaded with its starting state. The configuration inputs must stay fixed while `run` is high.

Top module: `ca_dma_engine`

## Requirements
- R1: While reset is asserted, and while `run` is low after reset, `mem_req` and `net_valid` are 0.
- R2: Each token carries `cfg_words` data words, and `cfg_words` is at least 1. Word i is read from local address `cfg_local_base + lslot*cfg_words + i` and written to remote address `cfg_remote_base + rslot*(cfg_words+1) + i`, in order of increasing i. After the data words comes one completion word at remote offset `cfg_words` within the slot. Its data is the number of tokens sent since `run` rose, counting this token, so the first token carries 1.
- R3: A local read holds `mem_req` high with a stable `mem_addr` until a cycle in which `mem_gnt` is high. The word is taken from `mem_rdata` in the cycle after that grant.
- R4: A remote write holds `net_valid` high with stable `net_addr` and `net_data` until `net_ready` is high. Every word is transferred exactly once and in order.
- R5: Each `tok_produced` pulse adds one filled token, and each token sent removes one. No token is started while the filled count is zero.
- R6: The credit count is loaded from `cfg_remote_tokens` while `run` is low. Each token started uses one credit and each `credit_ret` pulse returns one. No token is started while the credit count is zero.
- R7: After a token's completion word is accepted, the next token's first read request waits at least `cfg_interval` + 1 cycles. With a backlog, constant grant and constant ready, completion words are accepted exactly `cfg_interval + 3*cfg_words + 2` cycles apart.
- R8: The local slot index wraps modulo `cfg_local_tokens` and the remote slot index wraps modulo `cfg_remote_tokens`. Both start at 0 when `run` rises.
- R9: When `run` drops, `mem_req` and `net_valid` fall in the same cycle and the filled count is cleared. After `run` rises again, no transfer takes place until a new token is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Engine enable; while low, the engine is held idle and initialised |
| cfg_words | input | TOKW_W | Data words per token (at least 1) |
| cfg_local_tokens | input | BUFN_W | Local buffer size in tokens |
| cfg_remote_tokens | input | BUFN_W | Remote buffer size in tokens; initial credit count |
| cfg_interval | input | GAP_W | Idle cycles enforced between tokens |
| cfg_local_base | input | ADDR_W | Local buffer base address |
| cfg_remote_base | input | ADDR_W | Remote buffer base address |
| tok_produced | input | 1 | One-cycle pulse: the processor has filled one token |
| credit_ret | input | 1 | One-cycle pulse: the consumer has freed one remote slot |
| mem_req | output | 1 | Local memory read request to the arbiter |
| mem_addr | output | ADDR_W | Local read address |
| mem_gnt | input | 1 | Arbiter grant for the current request |
| mem_rdata | input | DATA_W | Read data, valid in the cycle after a grant |
| net_valid | output | 1 | Posted write valid toward the interconnect |
| net_addr | output | ADDR_W | Remote write address |
| net_data | output | DATA_W | Remote write data |
| net_ready | input | 1 | Interconnect accepts the current write |

## Verification
A wrong slot pointer or word index shows up at the interconnect port on the first word of the affected token, as a wrong address or a word taken from the wrong local slot. A wrong token counter shows up later, in the completion word's sequence value. Errors in the credit or filled counters show up as a token that is sent too early, or as one that never leaves once the expected credits or tokens have been supplied. A pacing error shows up as the spacing between completion words differing from `cfg_interval + 3*cfg_words + 2` when the engine has a backlog. Handshake faults are checked while grants and ready are withheld at random, so a dropped or repeated word breaks the scoreboard order on the next transfer.

// File: rtl/ca_dma_pkg.sv
package ca_dma_pkg;
  typedef enum logic [2:0] {
    XS_IDLE = 3'd0,
    XS_READ = 3'd1,
    XS_WAIT = 3'd2,
    XS_DATA = 3'd3,
    XS_SYNC = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/ca_token_tracker.sv
module ca_token_tracker #(
  parameter int BUFN_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BUFN_W-1:0] cfg_local_tokens,
  input  logic [BUFN_W-1:0] cfg_remote_tokens,
  input  logic              tok_produced,
  input  logic              credit_ret,
  input  logic              token_done,
  output logic [BUFN_W-1:0] filled,
  output logic [BUFN_W-1:0] credits,
  output logic [BUFN_W-1:0] lslot,
  output logic [BUFN_W-1:0] rslot,
  output logic [DATA_W-1:0] seq_num
);

  logic [BUFN_W-1:0] filled_n, credits_n, lslot_n, rslot_n;
  logic [DATA_W-1:0] sent_q, sent_n;
  logic              upd;

  assign upd = !run || tok_produced || credit_ret || token_done;

  always_comb begin
    filled_n  = filled;
    credits_n = credits;
    lslot_n   = lslot;
    rslot_n   = rslot;
    sent_n    = sent_q;
    if (!run) begin
      filled_n  = '0;
      credits_n = cfg_remote_tokens;
      lslot_n   = '0;
      rslot_n   = '0;
      sent_n    = '0;
    end else begin
      filled_n  = filled + BUFN_W'(tok_produced) - BUFN_W'(token_done);
      credits_n = credits + BUFN_W'(credit_ret) - BUFN_W'(token_done);
      if (token_done) begin
        lslot_n = (lslot == cfg_local_tokens - 1'b1) ? '0 : lslot + 1'b1;
        rslot_n = (rslot == cfg_remote_tokens - 1'b1) ? '0 : rslot + 1'b1;
        sent_n  = sent_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled  <= '0;
      credits <= '0;
      lslot   <= '0;
      rslot   <= '0;
      sent_q  <= '0;
    end else if (upd) begin
      filled  <= filled_n;
      credits <= credits_n;
      lslot   <= lslot_n;
      rslot   <= rslot_n;
      sent_q  <= sent_n;
    end
  end

  assign seq_num = sent_q + 1'b1;

  assert_done_needs_token_R5: assert property (@(posedge clk) disable iff (!rst_n)
    token_done |-> filled != '0);
  assert_filled_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> filled <= cfg_local_tokens);
  assert_done_needs_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    token_done |-> credits != '0);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> credits <= cfg_remote_tokens);
  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lslot < cfg_local_tokens) && (rslot < cfg_remote_tokens));

endmodule

// File: rtl/ca_pacer.sv
module ca_pacer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] cfg_interval,
  input  logic             token_done,
  output logic             pace_ok
);

  logic [GAP_W-1:0] gap_q, gap_n;
  logic             upd;

  assign upd = !run || token_done || (gap_q != '0);

  always_comb begin
    if (!run)              gap_n = '0;
    else if (token_done)   gap_n = cfg_interval;
    else if (gap_q != '0)  gap_n = gap_q - 1'b1;
    else                   gap_n = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gap_q <= '0;
    else if (upd) gap_q <= gap_n;
  end

  assign pace_ok = (gap_q == '0);

endmodule

// File: rtl/ca_xfer_fsm.sv
module ca_xfer_fsm
  import ca_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TOKW_W = 4,
  parameter int BUFN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TOKW_W-1:0] cfg_words,
  input  logic [ADDR_W-1:0] cfg_local_base,
  input  logic [ADDR_W-1:0] cfg_remote_base,
  input  logic [BUFN_W-1:0] lslot,
  input  logic [BUFN_W-1:0] rslot,
  input  logic [DATA_W-1:0] seq_num,
  input  logic              can_start,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              net_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              net_valid,
  output logic [ADDR_W-1:0] net_addr,
  output logic [DATA_W-1:0] net_data,
  output logic              tok_start,
  output logic              token_done
);

  localparam int OFF_W = BUFN_W + TOKW_W + 1;

  xfer_state_e       state_q, state_n;
  logic [TOKW_W-1:0] idx_q, idx_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [OFF_W-1:0]  loc_off, rem_off;

  assign loc_off  = OFF_W'(lslot) * OFF_W'(cfg_words) + OFF_W'(idx_q);
  assign rem_off  = OFF_W'(rslot) * (OFF_W'(cfg_words) + OFF_W'(1)) + OFF_W'(idx_q);
  assign mem_addr = cfg_local_base + ADDR_W'(loc_off);
  assign net_addr = cfg_remote_base + ADDR_W'(rem_off);
  assign net_data = (state_q == XS_SYNC) ? seq_num : data_q;

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    data_n     = data_q;
    mem_req    = 1'b0;
    net_valid  = 1'b0;
    tok_start  = 1'b0;
    token_done = 1'b0;
    if (!run) begin
      state_n = XS_IDLE;
      idx_n   = '0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (can_start) begin
            tok_start = 1'b1;
            idx_n     = '0;
            state_n   = XS_READ;
          end
        end
        XS_READ: begin
          mem_req = 1'b1;
          if (mem_gnt) state_n = XS_WAIT;
        end
        XS_WAIT: begin
          data_n  = mem_rdata;
          state_n = XS_DATA;
        end
        XS_DATA: begin
          net_valid = 1'b1;
          if (net_ready) begin
            idx_n   = idx_q + 1'b1;
            state_n = (idx_q == cfg_words - 1'b1) ? XS_SYNC : XS_READ;
          end
        end
        XS_SYNC: begin
          net_valid = 1'b1;
          if (net_ready) begin
            token_done = 1'b1;
            idx_n      = '0;
            state_n    = XS_IDLE;
          end
        end
        default: state_n = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      if (state_q == XS_WAIT) data_q <= data_n;
    end
  end

  assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (net_valid && !net_ready) |=> (net_valid && $stable(net_addr) && $stable(net_data)));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && net_valid));

endmodule

// File: rtl/ca_dma_engine.sv
module ca_dma_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TOKW_W = 4,
  parameter int BUFN_W = 4,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TOKW_W-1:0] cfg_words,
  input  logic [BUFN_W-1:0] cfg_local_tokens,
  input  logic [BUFN_W-1:0] cfg_remote_tokens,
  input  logic [GAP_W-1:0]  cfg_interval,
  input  logic [ADDR_W-1:0] cfg_local_base,
  input  logic [ADDR_W-1:0] cfg_remote_base,
  input  logic              tok_produced,
  input  logic              credit_ret,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              net_valid,
  output logic [ADDR_W-1:0] net_addr,
  output logic [DATA_W-1:0] net_data,
  input  logic              net_ready
);

  localparam int SINCE_W = GAP_W + 1;

  logic [BUFN_W-1:0] filled, credits, lslot, rslot;
  logic [DATA_W-1:0] seq_num;
  logic              pace_ok, can_start, tok_start, token_done;

  assign can_start = run && (filled != '0) && (credits != '0) && pace_ok;

  ca_token_tracker #(.BUFN_W(BUFN_W), .DATA_W(DATA_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_local_tokens(cfg_local_tokens), .cfg_remote_tokens(cfg_remote_tokens),
    .tok_produced(tok_produced), .credit_ret(credit_ret), .token_done(token_done),
    .filled(filled), .credits(credits), .lslot(lslot), .rslot(rslot),
    .seq_num(seq_num)
  );

  ca_pacer #(.GAP_W(GAP_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_interval(cfg_interval),
    .token_done(token_done), .pace_ok(pace_ok)
  );

  ca_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOKW_W(TOKW_W), .BUFN_W(BUFN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_words(cfg_words),
    .cfg_local_base(cfg_local_base), .cfg_remote_base(cfg_remote_base),
    .lslot(lslot), .rslot(rslot), .seq_num(seq_num), .can_start(can_start),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .net_ready(net_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .net_valid(net_valid),
    .net_addr(net_addr), .net_data(net_data),
    .tok_start(tok_start), .token_done(token_done)
  );

  // Pacing checker: cycles elapsed since the last completed token
  logic [SINCE_W-1:0] since_q;
  logic               seen_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      seen_done_q <= 1'b0;
    end else if (!run) begin
      since_q     <= '0;
      seen_done_q <= 1'b0;
    end else if (token_done) begin
      since_q     <= '0;
      seen_done_q <= 1'b1;
    end else if (since_q != {SINCE_W{1'b1}}) begin
      since_q     <= since_q + 1'b1;
    end
  end

  assert_pace_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_start && seen_done_q) |-> (since_q >= SINCE_W'(cfg_interval)));

endmodule

// File: tb/tb_ca_dma_engine.sv
module tb_ca_dma_engine;
  localparam int ADDR_W = 16, DATA_W = 16, TOKW_W = 4, BUFN_W = 4, GAP_W = 8;
  localparam logic [15:0] LBASE = 16'h0010;
  localparam logic [15:0] RBASE = 16'h4000;

  logic clk = 1'b0;
  logic rst_n, run, tok_produced, credit_ret, mem_gnt, net_ready;
  logic [TOKW_W-1:0] cfg_words;
  logic [BUFN_W-1:0] cfg_local_tokens, cfg_remote_tokens;
  logic [GAP_W-1:0]  cfg_interval;
  logic [ADDR_W-1:0] mem_addr, net_addr;
  logic [DATA_W-1:0] mem_rdata, net_data;
  logic mem_req, net_valid;

  always #2 clk = ~clk;

  ca_dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOKW_W(TOKW_W),
                  .BUFN_W(BUFN_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_words(cfg_words),
    .cfg_local_tokens(cfg_local_tokens), .cfg_remote_tokens(cfg_remote_tokens),
    .cfg_interval(cfg_interval), .cfg_local_base(LBASE), .cfg_remote_base(RBASE),
    .tok_produced(tok_produced), .credit_ret(credit_ret),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .net_valid(net_valid), .net_addr(net_addr), .net_data(net_data), .net_ready(net_ready)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] lmem [0:255];
  logic [15:0] lfsr = 16'hACE1;
  int gnt_mode = 0, net_mode = 0;   // 0 always, 1 random, 2 never
  logic [31:0] exp_q [$];
  int lp = 0, rp = 0, seqm = 0, produced = 0, sent = 0, hs_count = 0, req_cnt = 0;
  int credit_pend = 0;
  bit auto_credit = 0, pace_check = 0, have_last = 0;
  int exp_period = 0, last_sync = 0;
  string cur_req = "R2";

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // environment models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_gnt   <= (gnt_mode == 0) ? 1'b1 : (gnt_mode == 1) ? lfsr[0] : 1'b0;
    net_ready <= (net_mode == 0) ? 1'b1 : (net_mode == 1) ? lfsr[3] : 1'b0;
    if (mem_req && mem_gnt) mem_rdata <= lmem[mem_addr[7:0]];
    if (credit_pend > 0) begin
      credit_ret  <= 1'b1;
      credit_pend <= credit_pend - 1;
    end else credit_ret <= 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mem_req) req_cnt++;
    if (rst_n && net_valid && net_ready) begin
      hs_count++;
      if (exp_q.size() == 0) begin
        check(0, cur_req, "unexpected write addr", int'(net_addr), -1);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(net_addr == e[31:16], cur_req, "write addr", int'(net_addr), int'(e[31:16]));
        check(net_data == e[15:0],  cur_req, "write data", int'(net_data), int'(e[15:0]));
        if (e[31:16] == RBASE + 16'(rp_of(e)) ) ; // placeholder-free no-op guard
      end
      if (net_addr - RBASE >= 0 && is_sync(net_addr)) begin
        sent++;
        if (auto_credit) credit_pend++;
        if (pace_check && have_last)
          check(cyc - last_sync == exp_period, "R7", "completion spacing", cyc - last_sync, exp_period);
        last_sync = cyc;
        have_last = 1;
      end
    end
  end

  function automatic int rp_of(logic [31:0] e);
    return int'(e[31:16] - RBASE);
  endfunction

  function automatic bit is_sync(logic [15:0] a);
    int off;
    off = int'(a - RBASE) % (int'(cfg_words) + 1);
    return off == int'(cfg_words);
  endfunction

  task automatic configure(int w, int lt, int rt, int k);
    @(negedge clk);
    run = 1'b0;
    cfg_words = TOKW_W'(w); cfg_local_tokens = BUFN_W'(lt);
    cfg_remote_tokens = BUFN_W'(rt); cfg_interval = GAP_W'(k);
    exp_q.delete();
    lp = 0; rp = 0; seqm = 0; produced = 0; sent = 0; have_last = 0;
    repeat (2) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic produce();
    int w;
    w = int'(cfg_words);
    while (produced - sent >= int'(cfg_local_tokens)) @(negedge clk);
    seqm++;
    for (int i = 0; i < w; i++) begin
      logic [15:0] d;
      d = 16'h5A00 ^ 16'((seqm << 4) + i);
      lmem[8'(int'(LBASE) + lp * w + i)] = d;
      exp_q.push_back({16'(int'(RBASE) + rp * (w + 1) + i), d});
    end
    exp_q.push_back({16'(int'(RBASE) + rp * (w + 1) + w), 16'(seqm)});
    lp = (lp + 1) % int'(cfg_local_tokens);
    rp = (rp + 1) % int'(cfg_remote_tokens);
    produced++;
    tok_produced = 1'b1;
    @(negedge clk);
    tok_produced = 1'b0;
  endtask

  task automatic drain(string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, req, "words left after drain", exp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h0, r0;
    rst_n = 1'b0; run = 1'b0; tok_produced = 1'b0;
    cfg_words = 3; cfg_local_tokens = 4; cfg_remote_tokens = 4; cfg_interval = 0;
    repeat (4) @(negedge clk);
    check(mem_req == 0, "R1", "mem_req in reset", int'(mem_req), 0);
    check(net_valid == 0, "R1", "net_valid in reset", int'(net_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_req == 0 && net_valid == 0, "R1", "activity with run low", int'(mem_req | net_valid), 0);

    // basic transfer with back-to-back pacing
    cur_req = "R2";
    configure(3, 4, 4, 0);
    pace_check = 1; exp_period = 0 + 3 * 3 + 2;
    produce(); produce();
    drain("R2");
    pace_check = 0;

    // no token: engine stays quiet
    h0 = hs_count; r0 = req_cnt;
    repeat (30) @(negedge clk);
    check(hs_count == h0, "R5", "writes with no token", hs_count - h0, 0);
    check(req_cnt == r0, "R5", "reads with no token", req_cnt - r0, 0);

    // credits limit tokens in flight
    cur_req = "R6";
    configure(2, 4, 2, 0);
    auto_credit = 0;
    produce(); produce(); produce();
    repeat (60) @(negedge clk);
    check(sent == 2, "R6", "tokens sent without credit return", sent, 2);
    check(exp_q.size() == 3, "R6", "words held back", exp_q.size(), 3);
    credit_pend = credit_pend + 1;
    drain("R6");
    check(sent == 3, "R6", "tokens after credit return", sent, 3);

    // wrap, random grants and back-pressure
    cur_req = "R8";
    configure(2, 3, 2, 1);
    auto_credit = 1; gnt_mode = 1; net_mode = 1;
    for (int t = 0; t < 9; t++) produce();
    drain("R8");
    check(sent == 9, "R8", "tokens through wrapping buffers", sent, 9);
    gnt_mode = 0; net_mode = 0;
    repeat (10) @(negedge clk);

    // pacing interval
    cur_req = "R7";
    configure(2, 8, 8, 5);
    pace_check = 1; exp_period = 5 + 3 * 2 + 2;
    for (int t = 0; t < 4; t++) produce();
    drain("R7");
    pace_check = 0;

    // stall held by the engine, then run dropped
    cur_req = "R9";
    configure(2, 4, 4, 0);
    net_mode = 2;
    produce(); produce();
    repeat (12) @(negedge clk);
    check(net_valid == 1, "R4", "write held under back-pressure", int'(net_valid), 1);
    run = 1'b0;
    #1;
    check(net_valid == 0 && mem_req == 0, "R9", "outputs with run dropped", int'(net_valid | mem_req), 0);
    exp_q.delete();
    repeat (2) @(negedge clk);
    net_mode = 0;
    run = 1'b1;
    h0 = hs_count; r0 = req_cnt;
    repeat (30) @(negedge clk);
    check(hs_count == h0 && req_cnt == r0, "R9", "activity after restart", (hs_count - h0) + (req_cnt - r0), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule